// File: doc/BRIEF.md
# Streaming Frame SECDED Syndrome Checker

This block checks one configuration frame of 1312 bits as the frame streams past in 32-bit words. The frame already carries its own check bits: eleven Hamming check bits and one overall-parity bit. The block folds each accepted word into a running syndrome. When the last word of a frame has been taken, it presents a 12-bit syndrome, a one-cycle valid strobe, an error flag and a three-way classification: clean, single flip or double flip.

Each frame bit has an index, and that index is also its position code. The overall-parity bit has index 0. The Hamming check bits sit at the power-of-two indices. For a single flip, the low eleven syndrome bits give the index of the flipped bit directly. This holds when the flipped bit is one of the check bits too.

The upstream source opens each frame with a start marker on the first word. It then sends the remaining words in order and may insert idle cycles anywhere. The input side uses a valid/ready handshake. The block never applies back-pressure: `in_ready` is always high, so a word is consumed in every cycle that `in_valid` is high. A source that honours ready therefore behaves exactly as one that ignores it. The result registers hold their values until the next frame completes.

Top module: `frame_secded_chk`

## Requirements
- R1: While `rst` is high and after its release until the first frame completes, `syn_valid`, `syndrome`, `error` and `err_class` are all zero.
- R2: `in_ready` is high in every cycle. A word is accepted on every rising edge at which `in_valid` is high.
- R3: The k-th accepted word of a frame (k = 0 first) carries frame bits (40-k)*32+31 down to (40-k)*32, with lane j mapping to bit (40-k)*32+j. Bit 0 is the overall-parity bit. Bits 1, 2, 4, ..., 1024 are the Hamming check bits. `syndrome[10:0]` is the XOR of the indices of all set bits, and `syndrome[11]` is the XOR of all bits.
- R4: `syn_valid` is high for exactly one cycle. That cycle directly follows the rising edge that accepts the 41st word of a frame.
- R5: A correctly encoded frame gives `syndrome` = 0, `error` = 0 and `err_class` = 0 (clean).
- R6: A frame with exactly one flipped bit at index b, including bit 0 and any check bit, gives `syndrome[11]` = 1, `syndrome[10:0]` = b, `error` = 1 and `err_class` = 1 (single).
- R7: A frame with exactly two flipped bits gives `syndrome[11]` = 0, non-zero `syndrome[10:0]`, `error` = 1 and `err_class` = 2 (double).
- R8: A word with `in_sof` high always starts a new frame. Any partly received frame is discarded and produces no strobe.
- R9: Words accepted while no frame is open are ignored. A frame is open only between a start marker and its 41st word, so this covers words after reset or after a completed frame that arrive without a start marker. Such words produce no strobe and leave `syndrome`, `error` and `err_class` unchanged.
- R10: Between strobes, `syndrome`, `error` and `err_class` keep the values of the last completed frame.
- R11: The first word of a new frame may be accepted in the cycle right after the last word of the previous frame, and both frames are checked correctly.
- R12: Idle cycles (`in_valid` low) inside a frame do not change its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block accepts a word (always high) |
| in_data | input | 32 | Frame word, lane j = bit j |
| in_sof | input | 1 | Marks the first word of a frame |
| syn_valid | output | 1 | One-cycle strobe, result is ready |
| syndrome | output | 12 | Bit 11 overall parity, bits 10:0 position code |
| error | output | 1 | One or two bits flipped |
| err_class | output | 2 | 0 clean, 1 single, 2 double |

## Verification
All result outputs load at the same rising edge that accepts a frame's last word, so they are due exactly one cycle after that word is driven. The driver records the cycle number of that edge with each expected result in a scoreboard queue. The monitor samples on falling edges and requires the strobe to appear in exactly the recorded cycle. In the cycle after the strobe, the bench checks that the strobe has dropped and that the held outputs still match. Stray words and aborted partial frames push nothing into the queue, so any strobe they cause reaches an empty queue and is reported.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [1:0] {
    FSC_CLEAN  = 2'd0,
    FSC_SINGLE = 2'd1,
    FSC_DOUBLE = 2'd2
  } fsc_class_e;

  // Overall parity odd -> one flip; even parity with a non-zero position code -> two flips.
  function automatic fsc_class_e fsc_classify(input logic par_odd, input logic pos_nz);
    if (par_odd)     return FSC_SINGLE;
    else if (pos_nz) return FSC_DOUBLE;
    else             return FSC_CLEAN;
  endfunction

endpackage

// File: rtl/fsc_word_fold.sv
// Combinational fold of one word: XOR of the position codes of its set lanes, plus its parity.
// Position of lane j in word slot idx is {idx, j}, so the upper field only needs word parity.
module fsc_word_fold #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 5,
  parameter int IDX_W  = 6
) (
  input  logic [WORD_W-1:0]       word,
  input  logic [IDX_W-1:0]        idx,
  output logic [LANE_W+IDX_W-1:0] pos_xor,
  output logic                    par
);

  function automatic logic [WORD_W-1:0] lane_mask(input int unsigned sel);
    logic [WORD_W-1:0] m;
    for (int j = 0; j < WORD_W; j++) m[j] = ((j >> sel) & 1) != 0;
    return m;
  endfunction

  logic [LANE_W-1:0] lane_code;

  for (genvar k = 0; k < LANE_W; k++) begin : g_lane_bit
    localparam logic [WORD_W-1:0] MASK = lane_mask(k);
    assign lane_code[k] = ^(word & MASK);
  end

  assign par     = ^word;
  assign pos_xor = {(par ? idx : {IDX_W{1'b0}}), lane_code};

endmodule

// File: rtl/fsc_word_seq.sv
// Tracks frame membership and the descending slot index of each accepted word.
module fsc_word_seq #(
  parameter int NWORDS = 41,
  parameter int IDX_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             sof,
  output logic             first,
  output logic             use_w,
  output logic             last,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NWORDS - 1);

  logic             open_q;
  logic [IDX_W-1:0] next_q;

  assign first = take && sof;
  assign use_w = take && (sof || open_q);
  assign idx   = sof ? TOP_IDX : next_q;
  assign last  = use_w && (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      next_q <= '0;
    end else if (use_w) begin
      open_q <= !last;
      next_q <= idx - 1'b1;
    end
  end

endmodule

// File: rtl/fsc_result_reg.sv
// Registered result: syndrome, classification, error flag and one-cycle strobe.
module fsc_result_reg
  import fsc_pkg::*;
#(
  parameter int SYN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SYN_W-1:0] syn_in,
  output logic             valid,
  output logic [SYN_W-1:0] syn,
  output logic             err,
  output logic [1:0]       cls
);

  fsc_class_e cls_d;

  always_comb cls_d = fsc_classify(syn_in[SYN_W-1], |syn_in[SYN_W-2:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      syn   <= '0;
      err   <= 1'b0;
      cls   <= FSC_CLEAN;
    end else begin
      valid <= load;
      if (load) begin
        syn <= syn_in;
        cls <= cls_d;
        err <= (cls_d != FSC_CLEAN);
      end
    end
  end

endmodule

// File: rtl/frame_secded_chk.sv
module frame_secded_chk #(
  parameter int WORD_W     = 32,
  parameter int FRAME_BITS = 1312,
  localparam int NWORDS    = FRAME_BITS / WORD_W,
  localparam int LANE_W    = $clog2(WORD_W),
  localparam int IDX_W     = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int POS_W     = LANE_W + IDX_W,
  localparam int SYN_W     = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_sof,
  output logic              syn_valid,
  output logic [SYN_W-1:0]  syndrome,
  output logic              error,
  output logic [1:0]        err_class
);

  logic             take;
  logic             first, use_w, last;
  logic [IDX_W-1:0] idx;
  logic [POS_W-1:0] fold_pos;
  logic             fold_par;
  logic [POS_W-1:0] acc_pos_q, pos_d;
  logic             acc_par_q, par_d;

  assign in_ready = 1'b1;
  assign take     = in_valid && in_ready;

  fsc_word_seq #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .take  (take),
    .sof   (in_sof),
    .first (first),
    .use_w (use_w),
    .last  (last),
    .idx   (idx)
  );

  fsc_word_fold #(.WORD_W(WORD_W), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_fold (
    .word    (in_data),
    .idx     (idx),
    .pos_xor (fold_pos),
    .par     (fold_par)
  );

  // A start marker restarts the accumulation from zero.
  assign pos_d = (first ? {POS_W{1'b0}} : acc_pos_q) ^ fold_pos;
  assign par_d = (first ? 1'b0 : acc_par_q) ^ fold_par;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_pos_q <= '0;
      acc_par_q <= 1'b0;
    end else if (use_w) begin
      acc_pos_q <= pos_d;
      acc_par_q <= par_d;
    end
  end

  fsc_result_reg #(.SYN_W(SYN_W)) u_res (
    .clk    (clk),
    .rst    (rst),
    .load   (last),
    .syn_in ({par_d, pos_d}),
    .valid  (syn_valid),
    .syn    (syndrome),
    .err    (error),
    .cls    (err_class)
  );

endmodule

// File: rtl/fsc_chk.sv
module fsc_chk #(
  parameter int WORD_W     = 32,
  parameter int FRAME_BITS = 1312,
  localparam int NWORDS    = FRAME_BITS / WORD_W,
  localparam int LANE_W    = $clog2(WORD_W),
  localparam int IDX_W     = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int SYN_W     = LANE_W + IDX_W + 1,
  localparam int CNT_W     = IDX_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_sof,
  input logic             syn_valid,
  input logic [SYN_W-1:0] syndrome,
  input logic             error,
  input logic [1:0]       err_class
);

  logic             take, ending;
  logic [CNT_W-1:0] seen;

  assign take   = in_valid && in_ready;
  assign ending = take && ((in_sof && NWORDS == 1) ||
                           (!in_sof && seen != '0 && seen == CNT_W'(NWORDS - 1)));

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (take && in_sof) seen <= (NWORDS == 1) ? '0 : CNT_W'(1);
    else if (take && seen != '0) seen <= (seen == CNT_W'(NWORDS - 1)) ? '0 : seen + 1'b1;
  end

  // R4
  strobe_due_chk: assert property (@(posedge clk) disable iff (rst)
    ending |=> syn_valid);

  // R9
  no_stray_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    syn_valid |-> $past(ending));

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    (NWORDS > 1) && syn_valid |=> !syn_valid);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !syn_valid |-> ($stable(syndrome) && $stable(error) && $stable(err_class)));

  // R6
  single_class_chk: assert property (@(posedge clk) disable iff (rst)
    syn_valid && syndrome[SYN_W-1] |-> (err_class == 2'd1) && error);

  // R7
  double_class_chk: assert property (@(posedge clk) disable iff (rst)
    syn_valid && !syndrome[SYN_W-1] && (syndrome[SYN_W-2:0] != '0) |-> (err_class == 2'd2) && error);

  // R5
  clean_class_chk: assert property (@(posedge clk) disable iff (rst)
    syn_valid && (syndrome == '0) |-> (err_class == 2'd0) && !error);

endmodule

bind frame_secded_chk fsc_chk #(.WORD_W(WORD_W), .FRAME_BITS(FRAME_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sof    (in_sof),
  .syn_valid (syn_valid),
  .syndrome  (syndrome),
  .error     (error),
  .err_class (err_class)
);

// File: tb/frame_secded_chk_tb.sv
module frame_secded_chk_tb;

  localparam int WORD_W     = 32;
  localparam int FRAME_BITS = 1312;
  localparam int NW         = FRAME_BITS / WORD_W;

  typedef struct {
    logic [11:0] syn;
    logic        err;
    logic [1:0]  cls;
    longint      due;
    string       tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_sof = 1'b0;
  logic [WORD_W-1:0] in_data = '0;
  logic              in_ready, syn_valid, error;
  logic [11:0]       syndrome;
  logic [1:0]        err_class;

  int unsigned n_chk = 0;
  int unsigned n_fail = 0;
  longint      cyc = 0;
  exp_t        sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  frame_secded_chk #(.WORD_W(WORD_W), .FRAME_BITS(FRAME_BITS)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .syn_valid(syn_valid), .syndrome(syndrome), .error(error),
    .err_class(err_class)
  );

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FRAME_BITS-1:0] encode(input logic [FRAME_BITS-1:0] raw);
    logic [FRAME_BITS-1:0] f;
    logic [10:0] s;
    f = raw;
    s = '0;
    f[0] = 1'b0;
    for (int i = 0; i < 11; i++) f[1 << i] = 1'b0;
    for (int b = 1; b < FRAME_BITS; b++) if (f[b]) s ^= 11'(b);
    for (int i = 0; i < 11; i++) f[1 << i] = s[i];
    f[0] = ^f;
    return f;
  endfunction

  function automatic logic [FRAME_BITS-1:0] rand_frame();
    logic [FRAME_BITS-1:0] r;
    for (int k = 0; k < NW; k++) r[k*WORD_W +: WORD_W] = $urandom;
    return encode(r);
  endfunction

  function automatic exp_t mk_exp(input int nflip, input int a, input int b, input string tag);
    exp_t e;
    e.due = 0;
    e.tag = tag;
    if (nflip == 0) begin
      e.syn = '0; e.err = 1'b0; e.cls = 2'd0;
    end else if (nflip == 1) begin
      e.syn = {1'b1, 11'(a)}; e.err = 1'b1; e.cls = 2'd1;
    end else begin
      e.syn = {1'b0, 11'(a) ^ 11'(b)}; e.err = 1'b1; e.cls = 2'd2;
    end
    return e;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_data  = '0;
    end
  endtask

  task automatic drive_word(input logic [WORD_W-1:0] d, input logic sof);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    in_sof   = sof;
  endtask

  // Driver: sends nwords of frame f (first word with start marker) and queues the expected result.
  task automatic send(input logic [FRAME_BITS-1:0] f, input int nwords, input int gap_every,
                      input bit push, input exp_t e);
    exp_t q;
    q = e;
    for (int k = 0; k < nwords; k++) begin
      if (gap_every != 0 && k != 0 && (k % gap_every) == 0) idle(1);
      drive_word(f[(NW-1-k)*WORD_W +: WORD_W], k == 0);
      if (k == NW - 1 && push) begin
        q.due = cyc + 1;
        sb.push_back(q);
      end
    end
  endtask

  task automatic flip_frame(input int nflip, input int gap_every, input string tag,
                            output exp_t eo);
    logic [FRAME_BITS-1:0] f;
    int a, b;
    f = rand_frame();
    a = $urandom_range(FRAME_BITS - 1, 0);
    do b = $urandom_range(FRAME_BITS - 1, 0); while (b == a);
    if (nflip >= 1) f[a] = ~f[a];
    if (nflip == 2) f[b] = ~f[b];
    eo = mk_exp(nflip, a, b, tag);
    send(f, NW, gap_every, 1'b1, eo);
  endtask

  task automatic fixed_single(input int pos, input string tag);
    logic [FRAME_BITS-1:0] f;
    f = rand_frame();
    f[pos] = ~f[pos];
    send(f, NW, 0, 1'b1, mk_exp(1, pos, 0, tag));
  endtask

  // Monitor: pops the scoreboard on each strobe and compares values and arrival cycle.
  exp_t got;
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_valid && syn_valid) begin
        n_chk++; n_fail++;
        $display("FAIL R4 strobe width: actual 2+ cycles expected 1");
      end
      if (syn_valid) begin
        if (sb.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R9 R8 unexpected syn_valid: actual 1 expected 0");
        end else begin
          got = sb.pop_front();
          check(got.tag, "syndrome", syndrome, got.syn);
          check(got.tag, "error", error, got.err);
          check(got.tag, "err_class", err_class, got.cls);
          check("R4", "strobe cycle", cyc, got.due);
        end
      end
      prev_valid = syn_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    exp_t e;
    logic [11:0] held_syn;
    logic [1:0]  held_cls;
    void'($urandom(32'h5EC0DE));
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1", "syn_valid", syn_valid, 0);
    check("R1", "syndrome", syndrome, 0);
    check("R1", "error", error, 0);
    check("R1", "err_class", err_class, 0);
    rst = 1'b0;
    idle(2);
    check("R1", "syndrome after release", syndrome, 0);
    check("R2", "in_ready idle", in_ready, 1);

    // R5 clean frames
    flip_frame(0, 0, "R5", e);
    idle(1);
    idle(1);
    check("R4", "strobe dropped", syn_valid, 0);
    flip_frame(0, 0, "R5", e);
    check("R2", "in_ready during frame", in_ready, 1);
    idle(2);

    // R6 R3 single flips, random and at check or parity positions
    flip_frame(1, 0, "R6 R3", e);
    idle(4);
    // R10 outputs held after strobe
    check("R10", "syndrome held", syndrome, e.syn);
    check("R10", "err_class held", err_class, e.cls);
    fixed_single(0, "R6 R3");
    idle(1);
    fixed_single(1024, "R6 R3");
    idle(1);
    fixed_single(FRAME_BITS - 1, "R6 R3");
    idle(1);
    fixed_single(33, "R6 R3");
    idle(1);

    // R7 double flips
    for (int i = 0; i < 4; i++) begin
      flip_frame(2, 0, "R7", e);
      idle(1);
    end

    // R12 idle cycles inside a frame
    flip_frame(1, 3, "R12", e);
    idle(1);
    flip_frame(2, 7, "R12", e);
    idle(1);

    // R11 back-to-back frames
    flip_frame(1, 0, "R11", e);
    flip_frame(0, 0, "R11", e);
    flip_frame(2, 0, "R11", e);
    idle(2);

    // R8 restart: partial frame discarded, new start marker begins fresh
    send(rand_frame(), 17, 0, 1'b0, mk_exp(0, 0, 0, "R8"));
    flip_frame(1, 0, "R8", e);
    idle(2);
    send(rand_frame(), NW - 1, 0, 1'b0, mk_exp(0, 0, 0, "R8"));
    flip_frame(2, 0, "R8", e);
    idle(2);

    // R9 stray words without a start marker are ignored
    held_syn = syndrome;
    held_cls = err_class;
    for (int k = 0; k < NW + 3; k++) drive_word($urandom, 1'b0);
    idle(2);
    check("R9", "syndrome unchanged", syndrome, held_syn);
    check("R9", "err_class unchanged", err_class, held_cls);
    check("R9", "no strobe", syn_valid, 0);
    flip_frame(0, 0, "R9 R5", e);
    idle(5);

    check("R4", "all results delivered", sb.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule